// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block sits beside a two-bank SDRAM command bus and only listens. On every rising clock edge it turns the chip-select, row-strobe, column-strobe and write-enable levels into one command. It keeps a small state model for each bank: idle, row open, or inside a read or write burst that closes the row by itself when it ends. It compares each command with that model and with the state left by recent mode-register writes. Any illegal command raises a one-cycle error flag together with a class code.

Each error class also sets its own sticky bit, which stays set until the clear input is pulsed. A command that is flagged is treated as if it never happened, so the model keeps following what a correct device would do. Clock-enable handling follows the usual convention. When the clock enable was low on the previous edge, the bus carries no command on this edge. A refresh sampled while the clock enable falls is a self-refresh entry, and it is checked the same way as an auto refresh.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when `cs_n` is low and `cke` was high on the previous edge. Otherwise the edge counts as no-operation: no error and no change to any state. Encodings of {ras_n,cas_n,we_n}: 111 no-op, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 refresh, 000 mode register set.
- R2: A mode register set while either bank is not idle is flagged with code 1.
- R3: Any decoded command other than no-op on either of the two edges after an accepted mode register set is flagged with code 2.
- R4: A refresh, whether auto or self-refresh entry, while either bank is not idle is flagged with code 3.
- R5: A read or write to a bank inside its own auto-precharge burst is flagged with code 4. A read or write to the other bank is allowed, and it ends that burst, which returns the bursting bank to idle.
- R6: A read or write to an idle bank is flagged with code 5.
- R7: An activate to a bank that is not idle is flagged with code 6.
- R8: A precharge with `addr[10]` high returns both banks to idle whatever `ba` holds. With `addr[10]` low it idles only the bank that `ba` selects.
- R9: A burst stop is never flagged, except under R3. It ends any auto-precharge burst and returns that bank to idle.
- R10: A read or write with `addr[10]` high on an open bank starts an auto-precharge burst. The bank stays blocked for BL-1 edges and is idle from the BL-th edge after the command. BL is taken from `addr[2:0]` of the last accepted mode register set: 0→1, 1→2, 2→4, 3→8, any other value→PAGE_LEN (256). The value after reset is 1.
- R11: `err` is high for exactly the one cycle after the edge that sampled an illegal command. `err_code` then holds the lowest applicable code and is 0 otherwise. A flagged command changes no state.
- R12: Code k sets `err_sticky[k-1]`. A sticky bit stays set until `clear` is sampled high. When a clear and a new error fall on the same edge, the new error's bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank address |
| addr | input | 11 | Address bus; bit 10 is the auto-precharge / all-banks bit |
| clear | input | 1 | Clears the sticky bits |
| err | output | 1 | One-cycle illegal-command flag |
| err_code | output | 3 | Class of the flagged command, 0 when none |
| err_sticky | output | 6 | Sticky class bits |

## Verification
The bench targets burst-length boundaries. A design with an off-by-one in the auto-precharge countdown would flag a legal read on the edge where the bank has just gone idle, or it would miss the last blocked edge. Further directed cases cover the two-edge mode-register lockout, an all-banks precharge issued with the wrong bank address, and a command on the edge after the clock enable was low. A design that got these wrong would flag the third edge after the mode-register write, leave one bank open, or treat a suspended edge as a real command. Flagged commands are followed by commands whose legality depends on the flagged one having been ignored. A design that applied a rejected activate would therefore accept a later read that ought to fail.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_OPEN, BK_APB
  } bank_e;

  localparam int NUM_ERR = 6;
  // hit vector positions; error code is position + 1
  localparam int E_MRS_BUSY = 0;
  localparam int E_MRS_LOCK = 1;
  localparam int E_REF_BUSY = 2;
  localparam int E_AP_HIT   = 3;
  localparam int E_NO_ROW   = 4;
  localparam int E_ROW_OPEN = 5;

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
  import sdmon_pkg::*;
(
  input  logic cke_prev,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (cke_prev && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdmon_rules.sv
module sdmon_rules
  import sdmon_pkg::*;
#(
  parameter int BANK_W = 1,
  localparam int NB = 1 << BANK_W
) (
  input  cmd_e                 cmd,
  input  logic [BANK_W-1:0]    bank,
  input  bank_e [NB-1:0]       st,
  input  logic                 lock_active,
  output logic [NUM_ERR-1:0]   hit
);

  logic  any_busy;
  bank_e sel_st;
  logic  is_rw;

  always_comb begin
    any_busy = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (st[i] != BK_IDLE) any_busy = 1'b1;
    end
    sel_st = st[bank];
    is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);

    hit             = '0;
    hit[E_MRS_BUSY] = (cmd == CMD_MRS) && any_busy;
    hit[E_MRS_LOCK] = lock_active && (cmd != CMD_NOP);
    hit[E_REF_BUSY] = (cmd == CMD_REF) && any_busy;
    hit[E_AP_HIT]   = is_rw && (sel_st == BK_APB);
    hit[E_NO_ROW]   = is_rw && (sel_st == BK_IDLE);
    hit[E_ROW_OPEN] = (cmd == CMD_ACT) && (sel_st != BK_IDLE);
  end

endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
  import sdmon_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             ap,
  input  logic [CNT_W-1:0] burst_len,
  output bank_e            st
);

  bank_e            st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == BK_APB) begin
      if (cnt_q == CNT_W'(1)) st_d = BK_IDLE;
      else                    cnt_d = cnt_q - CNT_W'(1);
    end
    if (accept) begin
      case (cmd)
        CMD_ACT: if (sel) st_d = BK_OPEN;
        CMD_RD, CMD_WR: begin
          if (sel) begin
            if (ap) begin
              if (burst_len == CNT_W'(1)) begin
                st_d = BK_IDLE;
              end else begin
                st_d  = BK_APB;
                cnt_d = burst_len - CNT_W'(1);
              end
            end
          end else if (st_q == BK_APB) begin
            st_d = BK_IDLE;
          end
        end
        CMD_BST: if (st_q == BK_APB) st_d = BK_IDLE;
        CMD_PRE: if (sel || ap) st_d = BK_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st = st_q;

  // R10
  ap_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_APB) |-> (cnt_q != '0));

  // R8
  pre_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == CMD_PRE && ap) |=> (st_q == BK_IDLE));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BANK_W   = 1,
  parameter int AP_BIT   = 10,
  parameter int PAGE_LEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clear,
  output logic              err,
  output logic [2:0]        err_code,
  output logic [NUM_ERR-1:0] err_sticky
);

  localparam int NB    = 1 << BANK_W;
  localparam int CNT_W = $clog2(PAGE_LEN + 1);

  logic                cke_q;
  logic [1:0]          lock_q, lock_d;
  logic [CNT_W-1:0]    bl_q, bl_d;
  logic                err_q, err_d;
  logic [2:0]          code_q, code_d;
  logic [NUM_ERR-1:0]  sticky_q, sticky_d;
  cmd_e                cmd;
  bank_e [NB-1:0]      bank_st;
  logic [NUM_ERR-1:0]  hit;
  logic                accept;
  logic                mrs_ok;

  sdmon_decode u_dec (
    .cke_prev (cke_q),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd      (cmd)
  );

  sdmon_rules #(.BANK_W(BANK_W)) u_rules (
    .cmd         (cmd),
    .bank        (ba),
    .st          (bank_st),
    .lock_active (lock_q != 2'd0),
    .hit         (hit)
  );

  assign accept = (cmd != CMD_NOP) && (hit == '0);
  assign mrs_ok = accept && (cmd == CMD_MRS);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdmon_bank #(.CNT_W(CNT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .cmd       (cmd),
      .sel       (ba == BANK_W'(b)),
      .ap        (addr[AP_BIT]),
      .burst_len (bl_q),
      .st        (bank_st[b])
    );
  end

  always_comb begin
    lock_d = (lock_q != 2'd0) ? lock_q - 2'd1 : 2'd0;
    bl_d   = bl_q;
    if (mrs_ok) begin
      lock_d = 2'd2;
      case (addr[2:0])
        3'd0:    bl_d = CNT_W'(1);
        3'd1:    bl_d = CNT_W'(2);
        3'd2:    bl_d = CNT_W'(4);
        3'd3:    bl_d = CNT_W'(8);
        default: bl_d = CNT_W'(PAGE_LEN);
      endcase
    end
    err_d  = |hit;
    code_d = 3'd0;
    for (int k = NUM_ERR - 1; k >= 0; k--) begin
      if (hit[k]) code_d = 3'(k + 1);
    end
    sticky_d = (clear ? '0 : sticky_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q    <= 1'b0;
      lock_q   <= 2'd0;
      bl_q     <= CNT_W'(1);
      err_q    <= 1'b0;
      code_q   <= 3'd0;
      sticky_q <= '0;
    end else begin
      cke_q    <= cke;
      lock_q   <= lock_d;
      if (mrs_ok) bl_q <= bl_d;
      err_q    <= err_d;
      code_q   <= code_d;
      sticky_q <= sticky_d;
    end
  end

  assign err        = err_q;
  assign err_code   = code_q;
  assign err_sticky = sticky_q;

  // R11
  flag_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (code_q != 3'd0 && code_q <= 3'(NUM_ERR)));

  // R12
  sticky_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> sticky_q[code_q - 3'd1]);

  // R3
  lockout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != 2'd0 && cmd != CMD_NOP) |=> err_q);

  // R9
  burst_stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_BST && lock_q == 2'd0) |=> !err_q);

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

  localparam int PAGE = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n, clear;
  logic [0:0]  ba;
  logic [10:0] addr;
  logic        err;
  logic [2:0]  err_code;
  logic [5:0]  err_sticky;

  int nchk = 0;
  int nerr = 0;

  // reference model: 0 idle, 1 open, 2 auto-precharge burst
  int       m_st [2];
  int       m_cnt [2];
  int       m_bl;
  int       m_lock;
  bit       m_cke_q;
  bit [5:0] m_sticky;
  bit       e_err;
  int       e_code;

  always #10 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .clear(clear),
    .err(err), .err_code(err_code), .err_sticky(err_sticky)
  );

  function automatic string tag_of(input int code);
    case (code)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic int bl_of(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return PAGE;
    endcase
  endfunction

  // cmd: 0 nop 1 act 2 rd 3 wr 4 bst 5 pre 6 ref 7 mrs (R1 encodings)
  function automatic int dec(input bit c, input bit r, input bit ca, input bit w);
    if (!m_cke_q || c) return 0;
    case ({r, ca, w})
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b110: return 4;
      3'b010: return 5;
      3'b001: return 6;
      3'b000: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int  cmd;
    bit  busy, ap, rw;
    bit [5:0] h;
    int  b;
    cmd  = dec(cs_n, ras_n, cas_n, we_n);
    b    = int'(ba);
    ap   = addr[10];
    busy = (m_st[0] != 0) || (m_st[1] != 0);
    rw   = (cmd == 2) || (cmd == 3);
    h    = '0;
    h[0] = (cmd == 7) && busy;
    h[1] = (m_lock != 0) && (cmd != 0);
    h[2] = (cmd == 6) && busy;
    h[3] = rw && m_st[b] == 2;
    h[4] = rw && m_st[b] == 0;
    h[5] = (cmd == 1) && m_st[b] != 0;
    e_err  = |h;
    e_code = 0;
    for (int k = 5; k >= 0; k--) if (h[k]) e_code = k + 1;
    for (int i = 0; i < 2; i++) begin
      if (m_st[i] == 2) begin
        if (m_cnt[i] == 1) m_st[i] = 0;
        else m_cnt[i]--;
      end
    end
    if (m_lock != 0) m_lock--;
    if (cmd != 0 && !e_err) begin
      for (int i = 0; i < 2; i++) begin
        case (cmd)
          1: if (i == b) m_st[i] = 1;
          2, 3: begin
            if (i == b) begin
              if (ap) begin
                if (m_bl == 1) m_st[i] = 0;
                else begin m_st[i] = 2; m_cnt[i] = m_bl - 1; end
              end
            end else if (m_st[i] == 2) m_st[i] = 0;
          end
          4: if (m_st[i] == 2) m_st[i] = 0;
          5: if (i == b || ap) m_st[i] = 0;
          default: ;
        endcase
      end
      if (cmd == 7) begin
        m_lock = 2;
        m_bl = bl_of(int'(addr[2:0]));
      end
    end
    m_sticky = (clear ? 6'd0 : m_sticky) | h;
    m_cke_q  = cke;
  endtask

  task automatic cyc(input bit k, input bit c, input bit r, input bit ca,
                     input bit w, input bit bb, input bit [10:0] a, input bit clr);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = bb; addr = a; clear = clr;
    model_step();
    @(posedge clk);
    @(negedge clk);
    nchk++;
    if (err !== e_err || int'(err_code) != e_code || err_sticky !== m_sticky) begin
      nerr++;
      $display("FAIL %s: err=%0b code=%0d sticky=%b expected err=%0b code=%0d sticky=%b",
               tag_of(e_code != 0 ? e_code : int'(err_code)), err, err_code, err_sticky,
               e_err, e_code, m_sticky);
    end
  endtask

  task automatic expect_code(input int c, input string tag);
    nchk++;
    if (int'(err_code) != c || err !== (c != 0)) begin
      nerr++;
      $display("FAIL %s: err=%0b code=%0d expected code=%0d", tag, err, err_code, c);
    end
  endtask

  task automatic nop();                 cyc(1,0,1,1,1,0,11'd0,0); endtask
  task automatic act(input bit b);      cyc(1,0,0,1,1,b,11'd0,0); endtask
  task automatic rd(input bit b, input bit ap); cyc(1,0,1,0,1,b,{ap,10'd0},0); endtask
  task automatic wr(input bit b, input bit ap); cyc(1,0,1,0,0,b,{ap,10'd0},0); endtask
  task automatic bst();                 cyc(1,0,1,1,0,0,11'd0,0); endtask
  task automatic pre(input bit b, input bit ap); cyc(1,0,0,1,0,b,{ap,10'd0},0); endtask
  task automatic rfr();                 cyc(1,0,0,0,1,0,11'd0,0); endtask
  task automatic mrs(input bit [2:0] c); cyc(1,0,0,0,0,0,{8'd0,c},0); endtask
  task automatic mrs_q(input bit [2:0] c); mrs(c); nop(); nop(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    m_bl = 1; m_lock = 0; m_cke_q = 0; m_sticky = '0;
    rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    ba = 0; addr = '0; clear = 0;
    repeat (3) @(negedge clk);
    // R11 R12: reset state
    nchk++;
    if (err !== 1'b0 || err_code !== 3'd0 || err_sticky !== 6'd0) begin
      nerr++;
      $display("FAIL R12: reset err=%0b code=%0d sticky=%b expected 0 0 000000",
               err, err_code, err_sticky);
    end
    rst_n = 1;
    nop(); nop();

    // R6: read to idle bank
    rd(0, 0); expect_code(5, "R6");
    // R7: double activate, second ignored but row stays open
    act(0); expect_code(0, "R7");
    act(0); expect_code(6, "R7");
    // R2: mode register set with open row
    mrs(3'd2); expect_code(1, "R2");
    // R4: refresh with open row
    rfr(); expect_code(3, "R4");
    // R8: all-banks precharge addressed to bank 1 closes bank 0
    pre(1, 1); expect_code(0, "R8");
    rd(0, 0); expect_code(5, "R8");
    rfr(); expect_code(0, "R4");
    // R12: clear then clear with simultaneous error
    cyc(1,0,1,1,1,0,11'd0,1);
    nchk++;
    if (err_sticky !== 6'd0) begin
      nerr++; $display("FAIL R12: sticky=%b expected 000000", err_sticky);
    end
    cyc(1,0,1,0,1,1,11'd0,1); expect_code(5, "R12");
    nchk++;
    if (err_sticky !== 6'b010000) begin
      nerr++; $display("FAIL R12: sticky=%b expected 010000", err_sticky);
    end
    // R3: lockout covers two edges; rejected activate is ignored (R11)
    mrs(3'd2); expect_code(0, "R3");
    act(1); expect_code(2, "R3");
    act(1); expect_code(2, "R3");
    rd(1, 0); expect_code(5, "R11");
    act(1); expect_code(0, "R3");
    pre(0, 1);
    // R1: deselect with garbage strobes, and edge after cke low
    cyc(1,1,0,0,0,0,11'd0,0); expect_code(0, "R1");
    act(0);
    cyc(0,0,1,1,1,0,11'd0,0);
    cyc(1,0,0,1,1,0,11'd0,0); expect_code(0, "R1");
    pre(0, 1);
    // R10: BL4 auto-precharge window
    act(0); wr(0, 1);
    rd(0, 0); expect_code(4, "R10");
    nop();
    rd(0, 0); expect_code(4, "R10");
    rd(0, 0); expect_code(5, "R10");
    // R5: other bank read ends the burst
    act(1); act(0); rd(0, 1);
    rd(1, 0); expect_code(0, "R5");
    act(0); expect_code(0, "R5");
    pre(0, 1);
    // R9: burst stop ends auto-precharge burst
    act(0); rd(0, 1);
    bst(); expect_code(0, "R9");
    act(0); expect_code(0, "R9");
    pre(0, 1);
    // R10: BL1 closes at once
    mrs_q(3'd0);
    act(0); rd(0, 1);
    rd(0, 0); expect_code(5, "R10");
    // R10: full page burst, stopped early
    mrs_q(3'd7);
    act(1); wr(1, 1);
    repeat (20) nop();
    wr(1, 0); expect_code(4, "R10");
    bst();
    // self refresh entry while idle, then exit
    pre(0, 1);
    cyc(0,0,0,0,1,0,11'd0,0); expect_code(0, "R4");
    cyc(1,1,1,1,1,0,11'd0,0);
    mrs_q(3'd2);

    // constrained random mix
    void'($urandom(32'h5D1A_0C3B));
    for (int n = 0; n < 4000; n++) begin
      int p, sel;
      bit k, c, bb, clr;
      bit [10:0] a;
      bit [2:0] enc;
      p   = int'($urandom_range(0, 99));
      k   = ($urandom_range(0, 99) >= 3);
      c   = ($urandom_range(0, 99) < 5);
      bb  = 1'($urandom_range(0, 1));
      clr = ($urandom_range(0, 99) < 2);
      a   = 11'($urandom);
      if (p < 30)      enc = 3'b111;
      else if (p < 45) enc = 3'b011;
      else if (p < 60) enc = 3'b101;
      else if (p < 75) enc = 3'b100;
      else if (p < 82) enc = 3'b010;
      else if (p < 88) enc = 3'b110;
      else if (p < 94) enc = 3'b001;
      else begin
        enc = 3'b000;
        sel = int'($urandom_range(0, 9));
        a[2:0] = (sel == 0) ? 3'd7 : 3'(sel % 4);
      end
      cyc(k, c, enc[2], enc[1], enc[0], bb, a, clr);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule